// File: doc/BRIEF.md
# Multiply-by-Squaring Unit

This block multiplies two 4-bit unsigned operands without any multiplier cell. It forms the sum of the operands and the magnitude of their difference, reads the square of each from a constant square table, subtracts the two squares and drops the two low bits. The identity behind it is that four times a product equals the square of the sum minus the square of the difference. The difference is taken as the first operand plus the inverted second operand plus one. The carry out of that addition gives the sign, and when the carry is clear the result is negated to give the magnitude.

The caller presents both operands together with a one-cycle start strobe. The table reads are registered, so the product and a one-cycle valid pulse appear on the clock edge after the strobe is sampled. The product then holds until the next strobe. A parameter selects how the tables are built: two single-port square tables, or one shared table with two read ports.

A two-state controller tracks the result. In `IDLE` no fresh result is shown. In `SHOW` a product computed on the previous edge is on the output. The transitions are:
- IDLE->SHOW when the strobe is high.
- SHOW->SHOW when another strobe arrives.
- SHOW->IDLE when there is no strobe.

Top module: `sqmul_unit`

## Requirements
- R1: On the clock edge after a cycle with `start` high, `product` equals `mul_a` * `mul_b` as sampled in that cycle. This holds for all 256 operand pairs.
- R2: `res_valid` is high in exactly the cycle after each cycle in which `start` is high, and low otherwise.
- R3: Strobes on consecutive cycles each produce their own product on the following edge, and `res_valid` stays high for the whole run.
- R4: While `start` is low, `product` holds the last result, and changes on `mul_a` and `mul_b` have no effect on it.
- R5: While `rst_n` is low (active-low, asynchronous), `product` is 0 and `res_valid` is 0.
- R6: The result does not depend on operand order, so `mul_a` below `mul_b` (negative difference, carry out 0) gives the same product as the swapped pair (carry out 1). Equal operands give the square.
- R7: With `SHARED_TABLE` = 1 (one table with two read ports), the outputs match the `SHARED_TABLE` = 0 build (two single-port tables) cycle for cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; table reads and state update on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Operand strobe; operands are sampled when high |
| mul_a | input | 4 | First unsigned operand |
| mul_b | input | 4 | Second unsigned operand |
| product | output | 8 | Unsigned product, held between strobes |
| res_valid | output | 1 | One-cycle pulse marking a fresh product |

## Verification
Two things can happen in the same cycle:
- presenting the previous result with `res_valid` high in state `SHOW`;
- sampling a new operand pair through the table read.

The bench provokes this with a burst of back-to-back strobes whose operands alternate between pairs with a negative difference and pairs with a positive one. At each cycle it judges that `product` has moved to the new pair's product while `res_valid` never drops. The full 256-pair sweep runs on both table builds side by side, so any divergence between the builds is caught at the same sample point.

// File: rtl/sqmul_pkg.sv
package sqmul_pkg;
    localparam int OPW   = 4;
    localparam int SUMW  = OPW + 1;
    localparam int SQW   = 2 * SUMW;
    localparam int PW    = 2 * OPW;
    localparam int DEPTH = 1 << SUMW;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } sqmul_state_t;

    // constant square table, 32 entries of 10 bits
    function automatic logic [SQW-1:0] square_of(input logic [SUMW-1:0] n);
        logic [SQW-1:0] r;
        unique case (n)
            5'd0:  r = 10'd0;
            5'd1:  r = 10'd1;
            5'd2:  r = 10'd4;
            5'd3:  r = 10'd9;
            5'd4:  r = 10'd16;
            5'd5:  r = 10'd25;
            5'd6:  r = 10'd36;
            5'd7:  r = 10'd49;
            5'd8:  r = 10'd64;
            5'd9:  r = 10'd81;
            5'd10: r = 10'd100;
            5'd11: r = 10'd121;
            5'd12: r = 10'd144;
            5'd13: r = 10'd169;
            5'd14: r = 10'd196;
            5'd15: r = 10'd225;
            5'd16: r = 10'd256;
            5'd17: r = 10'd289;
            5'd18: r = 10'd324;
            5'd19: r = 10'd361;
            5'd20: r = 10'd400;
            5'd21: r = 10'd441;
            5'd22: r = 10'd484;
            5'd23: r = 10'd529;
            5'd24: r = 10'd576;
            5'd25: r = 10'd625;
            5'd26: r = 10'd676;
            5'd27: r = 10'd729;
            5'd28: r = 10'd784;
            5'd29: r = 10'd841;
            5'd30: r = 10'd900;
            default: r = 10'd961;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/sqmul_absdiff.sv
module sqmul_absdiff
    import sqmul_pkg::*;
(
    input  logic [OPW-1:0]  lhs,
    input  logic [OPW-1:0]  rhs,
    output logic [OPW-1:0]  magnitude,
    output logic            non_neg
);
    logic [OPW:0]   raw;
    logic [OPW-1:0] low;

    // one adder: lhs + ~rhs + 1, carry out marks lhs >= rhs
    always_comb begin
        raw       = {1'b0, lhs} + {1'b0, ~rhs} + {{OPW{1'b0}}, 1'b1};
        low       = raw[OPW-1:0];
        non_neg   = raw[OPW];
        magnitude = non_neg ? low : (~low + {{(OPW-1){1'b0}}, 1'b1});
    end
endmodule

// File: rtl/sqmul_sqrom.sv
module sqmul_sqrom
    import sqmul_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_en,
    input  logic [SUMW-1:0] addr,
    output logic [SQW-1:0]  data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            data <= '0;
        else if (rd_en)
            data <= square_of(addr);
    end
endmodule

// File: rtl/sqmul_sqrom_dp.sv
module sqmul_sqrom_dp
    import sqmul_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_en,
    input  logic [SUMW-1:0] addr_p,
    input  logic [SUMW-1:0] addr_q,
    output logic [SQW-1:0]  data_p,
    output logic [SQW-1:0]  data_q
);
    logic [SQW-1:0] table_mem [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++)
            table_mem[i] = square_of(SUMW'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_p <= '0;
            data_q <= '0;
        end else if (rd_en) begin
            data_p <= table_mem[addr_p];
            data_q <= table_mem[addr_q];
        end
    end
endmodule

// File: rtl/sqmul_ctrl.sv
module sqmul_ctrl
    import sqmul_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic show
);
    sqmul_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = start ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_nx = start ? ST_SHOW : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_SHOW: show = 1'b1;
            default: show = 1'b0;
        endcase
    end
endmodule

// File: rtl/sqmul_unit.sv
module sqmul_unit
    import sqmul_pkg::*;
#(
    parameter bit SHARED_TABLE = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [OPW-1:0] mul_a,
    input  logic [OPW-1:0] mul_b,
    output logic [PW-1:0]  product,
    output logic           res_valid
);
    logic [SUMW-1:0] sum_ab;
    logic [OPW-1:0]  mag_ab;
    logic            ab_non_neg;
    logic [SQW-1:0]  sq_sum;
    logic [SQW-1:0]  sq_mag;

    assign sum_ab = {1'b0, mul_a} + {1'b0, mul_b};

    sqmul_absdiff u_diff (
        .lhs       (mul_a),
        .rhs       (mul_b),
        .magnitude (mag_ab),
        .non_neg   (ab_non_neg)
    );

    generate
        if (SHARED_TABLE) begin : g_shared
            sqmul_sqrom_dp u_tab (
                .clk    (clk),
                .rst_n  (rst_n),
                .rd_en  (start),
                .addr_p (sum_ab),
                .addr_q ({1'b0, mag_ab}),
                .data_p (sq_sum),
                .data_q (sq_mag)
            );
        end else begin : g_split
            sqmul_sqrom u_tab_sum (
                .clk   (clk),
                .rst_n (rst_n),
                .rd_en (start),
                .addr  (sum_ab),
                .data  (sq_sum)
            );
            sqmul_sqrom u_tab_mag (
                .clk   (clk),
                .rst_n (rst_n),
                .rd_en (start),
                .addr  ({1'b0, mag_ab}),
                .data  (sq_mag)
            );
        end
    endgenerate

    // difference of squares is a non-negative multiple of four
    assign product = PW'((sq_sum - sq_mag) >> 2);

    sqmul_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .show  (res_valid)
    );

    logic sign_unused;
    assign sign_unused = ab_non_neg;
endmodule

// File: rtl/sqmul_unit_chk.sv
module sqmul_unit_chk
    import sqmul_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [OPW-1:0] mul_a,
    input logic [OPW-1:0] mul_b,
    input logic [PW-1:0]  product,
    input logic           res_valid
);
    // R1
    product_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (product == PW'($past(mul_a) * $past(mul_b))));

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> res_valid);

    // R2
    valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !res_valid);

    // R4
    product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(product));

    // R5
    always @(posedge clk) begin
        if (!rst_n)
            reset_clear_chk: assert (product == '0 && !res_valid);
    end
endmodule

bind sqmul_unit sqmul_unit_chk u_chk (.*);

// File: tb/sqmul_unit_test.sv
`timescale 1ns/1ps
module sqmul_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] mul_a = '0;
    logic [3:0] mul_b = '0;
    logic [7:0] product, product_dp;
    logic       res_valid, res_valid_dp;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sqmul_unit #(.SHARED_TABLE(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mul_a(mul_a), .mul_b(mul_b),
        .product(product), .res_valid(res_valid));

    sqmul_unit #(.SHARED_TABLE(1'b1)) uut_dp (
        .clk(clk), .rst_n(rst_n), .start(start), .mul_a(mul_a), .mul_b(mul_b),
        .product(product_dp), .res_valid(res_valid_dp));

    // {a, b, expected product}
    localparam logic [15:0] VEC [8] = '{
        {4'd0,  4'd0,  8'd0},
        {4'd15, 4'd15, 8'd225},
        {4'd3,  4'd5,  8'd15},
        {4'd5,  4'd3,  8'd15},
        {4'd1,  4'd15, 8'd15},
        {4'd12, 4'd11, 8'd132},
        {4'd7,  4'd7,  8'd49},
        {4'd0,  4'd9,  8'd0}
    };

    task automatic check(input string req, input int actual, input int expected);
        n_chk++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic apply(input logic [3:0] a, input logic [3:0] b);
        start = 1'b1; mul_a = a; mul_b = b;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
        end
    end

    initial begin
        // R5: reset state
        repeat (3) @(negedge clk);
        check("R5 product", int'(product), 0);
        check("R5 valid", int'(res_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle valid", int'(res_valid), 0);

        // R1 R6: vector table
        for (int i = 0; i < 8; i++) begin
            apply(VEC[i][15:12], VEC[i][11:8]);
            check("R1 vector", int'(product), int'(VEC[i][7:0]));
            check("R2 valid pulse", int'(res_valid), 1);
            check("R7 vector", int'(product_dp), int'(product));
        end

        // R1 R7: full sweep on both builds
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                apply(4'(a), 4'(b));
                check("R1 sweep", int'(product), a * b);
                check("R7 sweep", int'(product_dp), a * b);
                check("R7 valid", int'(res_valid_dp), int'(res_valid));
            end
        end

        // R6: operand order, both carry signs
        apply(4'd2, 4'd13);
        check("R6 a<b", int'(product), 26);
        apply(4'd13, 4'd2);
        check("R6 a>b", int'(product), 26);

        // R4: held result, inputs ignored without strobe
        apply(4'd9, 4'd6);
        check("R2 valid", int'(res_valid), 1);
        mul_a = 4'd15; mul_b = 4'd15;
        @(negedge clk);
        check("R4 hold", int'(product), 54);
        check("R2 drop", int'(res_valid), 0);
        mul_a = 4'd1; mul_b = 4'd0;
        repeat (3) @(negedge clk);
        check("R4 hold late", int'(product), 54);
        check("R4 hold dp", int'(product_dp), 54);

        // R3: back-to-back strobes, alternating difference sign
        start = 1'b1;
        for (int k = 0; k < 8; k++) begin
            mul_a = (k % 2) ? 4'(k + 5) : 4'(k);
            mul_b = (k % 2) ? 4'(k) : 4'(k + 6);
            @(negedge clk);
            check("R3 burst product", int'(product),
                  (k % 2) ? (k + 5) * k : k * (k + 6));
            check("R3 burst valid", int'(res_valid), 1);
        end
        start = 1'b0;
        @(negedge clk);
        check("R3 burst end", int'(res_valid), 0);

        // R5: reset mid-run clears
        rst_n = 1'b0;
        #1;
        check("R5 async product", int'(product), 0);
        check("R5 async valid", int'(res_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1;
        summary();
    end
endmodule